// File: doc/BRIEF.md
# Vector Bytewise GF(2) Affine Unit

This block applies a bit-level affine map over GF(2) to each of the 64 byte lanes of a 512-bit vector in parallel. Each output byte is an 8x8 bit matrix multiplied by the input byte, then XORed with a constant byte. In this arithmetic a product is a bitwise AND and a sum is an XOR, so no carry ever moves between bit positions. The matrix operand is 512 bits wide and holds eight 64-bit matrices. Each matrix serves one group of eight neighbouring data bytes. A single 8-bit constant is applied to every lane.

A per-byte enable mask sets which lanes take the computed value. A lane whose mask bit is clear either keeps the matching byte of a supplied prior-destination vector (merge) or is forced to zero (zeroing). The result is registered one cycle after the operation is presented, and a new operation can be accepted on every cycle.

The valid tracking is a two-state machine:
- State `ST_EMPTY` means the output holds no fresh result.
- State `ST_FULL` means the output carries the result of the operation accepted on the previous edge.
- The transition `fill` moves from EMPTY to FULL when `in_valid` is high.
- The transition `stream` keeps the machine in FULL when `in_valid` is high.
- The transition `drain` moves from FULL to EMPTY when `in_valid` is low.
- The transition `idle` keeps the machine in EMPTY when `in_valid` is low.

Top module: `gf2_affine_vec`

## Requirements
- R1: Bit i of a lane's raw value is the parity of (input byte AND matrix byte 7-i) XOR constant bit i. Matrix byte j is bits 8j+7..8j of that lane's 64-bit matrix.
- R2: A matrix of 0x0102040810204080 (matrix byte 7 = 0x01 ... matrix byte 0 = 0x80) with constant 0x00 and all mask bits set returns the data unchanged.
- R3: A matrix of 0x8040201008040201 with constant 0x00 reverses the bit order of every byte.
- R4: Matrix k (bits 64k+63..64k of `matrix_in`) is used only for data bytes 8k..8k+7.
- R5: The constant is applied identically to all 64 lanes. With an all-zero matrix, every enabled lane equals the constant.
- R6: When mask bit n is 1, result byte n (bits 8n+7..8n) is the computed affine value.
- R7: When mask bit n is 0 and `zero_mode` is 0, result byte n equals byte n of `prior_in`.
- R8: When mask bit n is 0 and `zero_mode` is 1, result byte n is 0x00.
- R9: An operation presented with `in_valid` high appears on `result`, with `out_valid` high, after exactly one rising clock edge.
- R10: Operations on consecutive cycles each produce their own result on consecutive cycles.
- R11: While `in_valid` is low, `result` holds its value and `out_valid` is low from the next edge on.
- R12: After reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| data_in | input | 512 | 64 data bytes, byte n at bits 8n+7..8n |
| matrix_in | input | 512 | Eight 64-bit matrices, one per 8-byte group |
| const_in | input | 8 | Constant XORed into every lane |
| mask_in | input | 64 | Per-byte enable, bit n for byte n |
| zero_mode | input | 1 | 1: disabled lanes become zero; 0: they merge |
| prior_in | input | 512 | Prior destination bytes used for merging |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 512 | Registered masked affine result |

## Verification
The bench checks the identity and bit-reverse matrices. A design that reads the matrix rows in the wrong order fails both: it either reverses bytes that should pass through or leaves unchanged bytes that should be reversed. Giving each group its own matrix exposes a design that indexes the wrong 64-bit block, because its lanes then take the neighbouring group's transform. Mixed masks are run in both merge and zeroing mode, so swapping the two modes or ignoring the mask corrupts disabled bytes. Back-to-back operations followed by idle cycles catch a result register that drops data or changes while no operation is present.

// File: rtl/gfa_pkg.sv
package gfa_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] lane_byte_t;
    typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} gfa_state_e;
endpackage

// File: rtl/gfa_lane.sv
module gfa_lane
    import gfa_pkg::*;
(
    input  lane_byte_t               x_in,
    input  logic [BYTE_W*BYTE_W-1:0] mat_in,
    input  lane_byte_t               cst_in,
    input  logic                     enable,
    input  logic                     zmode,
    input  lane_byte_t               prior,
    output lane_byte_t               y_out
);
    lane_byte_t raw;

    // output bit i pairs with matrix byte (BYTE_W-1-i)
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign raw[i] = (^(x_in & mat_in[BYTE_W*(BYTE_W-1-i) +: BYTE_W])) ^ cst_in[i];
    end

    always_comb begin
        if (enable)      y_out = raw;
        else if (zmode)  y_out = '0;
        else             y_out = prior;
    end
endmodule

// File: rtl/gfa_group.sv
module gfa_group
    import gfa_pkg::*;
#(
    parameter int LANES_PER_GROUP = 8,
    localparam int GW = LANES_PER_GROUP * BYTE_W
) (
    input  logic [GW-1:0]              data_g,
    input  logic [BYTE_W*BYTE_W-1:0]   mat_g,
    input  lane_byte_t                 cst,
    input  logic [LANES_PER_GROUP-1:0] mask_g,
    input  logic                       zmode,
    input  logic [GW-1:0]              prior_g,
    output logic [GW-1:0]              res_g
);
    for (genvar l = 0; l < LANES_PER_GROUP; l++) begin : g_lane
        gfa_lane u_lane (
            .x_in   (data_g[l*BYTE_W +: BYTE_W]),
            .mat_in (mat_g),
            .cst_in (cst),
            .enable (mask_g[l]),
            .zmode  (zmode),
            .prior  (prior_g[l*BYTE_W +: BYTE_W]),
            .y_out  (res_g[l*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/gf2_affine_vec.sv
module gf2_affine_vec
    import gfa_pkg::*;
#(
    parameter int NUM_GROUPS      = 8,
    parameter int LANES_PER_GROUP = 8,
    localparam int LANES = NUM_GROUPS * LANES_PER_GROUP,
    localparam int VEC_W = LANES * BYTE_W,
    localparam int GW    = LANES_PER_GROUP * BYTE_W,
    localparam int MAT_W = BYTE_W * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] data_in,
    input  logic [NUM_GROUPS*MAT_W-1:0] matrix_in,
    input  logic [BYTE_W-1:0] const_in,
    input  logic [LANES-1:0] mask_in,
    input  logic             zero_mode,
    input  logic [VEC_W-1:0] prior_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    gfa_state_e       state_q, state_d;
    logic [VEC_W-1:0] next_res;

    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        gfa_group #(.LANES_PER_GROUP(LANES_PER_GROUP)) u_grp (
            .data_g  (data_in[k*GW +: GW]),
            .mat_g   (matrix_in[k*MAT_W +: MAT_W]),
            .cst     (const_in),
            .mask_g  (mask_in[k*LANES_PER_GROUP +: LANES_PER_GROUP]),
            .zmode   (zero_mode),
            .prior_g (prior_in[k*GW +: GW]),
            .res_g   (next_res[k*GW +: GW])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;   // fill
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;  // drain
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= next_res;
    end

    assign out_valid = (state_q == ST_FULL);

    assert_valid_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    assert_zeroing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && mask_in == '0) |=> (result == '0));
    assert_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && mask_in == '0) |=> (result == $past(prior_in)));
    assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_in == '1 && const_in == '0 &&
         matrix_in == {NUM_GROUPS{64'h0102040810204080}}) |=> (result == $past(data_in)));
endmodule

// File: tb/sim_gf2_affine_vec.sv
module sim_gf2_affine_vec;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] M_ID  = 64'h0102040810204080;
    localparam logic [63:0] M_REV = 64'h8040201008040201;
    localparam logic [63:0] M_ARB = 64'h1F2E3D4C5B6A7988;

    typedef struct packed {
        logic [63:0] mat;
        logic [7:0]  cst;
        logic [7:0]  seed;
        logic [63:0] mask;
        logic        zm;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{M_ID,  8'h00, 8'h3C, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R2 R6 identity
        '{M_REV, 8'h00, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R3 bit reverse
        '{64'h0, 8'hA7, 8'h11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R5 constant only
        '{M_ARB, 8'h63, 8'hC9, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R1 general
        '{M_ARB, 8'h63, 8'h77, 64'hF0F0_0FF0_1234_8001, 1'b0}, // R7 mixed merge
        '{M_ARB, 8'h1D, 8'h77, 64'hF0F0_0FF0_1234_8001, 1'b1}, // R8 mixed zeroing
        '{M_ID,  8'h55, 8'h92, 64'h0, 1'b0}                    // R7 all merged
    };

    logic clk = 0, rst_n = 0, in_valid = 0, zero_mode = 0;
    logic [511:0] data_in = '0, matrix_in = '0, prior_in = '0;
    logic [7:0]   const_in = '0;
    logic [63:0]  mask_in = '0;
    logic         out_valid;
    logic [511:0] result;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf2_affine_vec u0 (.clk, .rst_n, .in_valid, .data_in, .matrix_in, .const_in,
                       .mask_in, .zero_mode, .prior_in, .out_valid, .result);

    function automatic logic [511:0] mk_data(input logic [7:0] s);
        logic [511:0] v;
        for (int n = 0; n < 64; n++) v[8*n +: 8] = s ^ 8'(n*29 + 7);
        return v;
    endfunction

    function automatic logic [511:0] mk_prior(input logic [7:0] s);
        logic [511:0] v;
        for (int n = 0; n < 64; n++) v[8*n +: 8] = ~s ^ 8'(n);
        return v;
    endfunction

    function automatic logic [511:0] model(input logic [511:0] d, input logic [511:0] m,
        input logic [7:0] b, input logic [63:0] k, input logic z, input logic [511:0] p);
        logic [511:0] r;
        for (int n = 0; n < 64; n++) begin
            logic [7:0] y;
            logic [63:0] a;
            a = m[64*(n/8) +: 64];
            y = b;
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    y[i] = y[i] ^ (d[8*n+j] & a[8*(7-i)+j]);
            r[8*n +: 8] = k[n] ? y : (z ? 8'h00 : p[8*n +: 8]);
        end
        return r;
    endfunction

    task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [511:0] d, input logic [511:0] m, input logic [7:0] b,
                         input logic [63:0] k, input logic z, input logic [511:0] p);
        data_in = d; matrix_in = m; const_in = b; mask_in = k; zero_mode = z; prior_in = p;
        in_valid = 1;
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [511:0] e1, e2, held, mg;
        // R12 reset state
        #(CLK_PERIOD*3);
        chk_bit("R12 out_valid at reset", out_valid, 1'b0);
        chk_vec("R12 result at reset", result, '0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk_bit("R12 out_valid after reset", out_valid, 1'b0);

        // Table walk: R1 R2 R3 R5 R6 R7 R8 R9
        for (int t = 0; t < NV; t++) begin
            logic [511:0] d, p, m, e;
            d = mk_data(TABLE[t].seed);
            p = mk_prior(TABLE[t].seed);
            m = {8{TABLE[t].mat}};
            e = model(d, m, TABLE[t].cst, TABLE[t].mask, TABLE[t].zm, p);
            drive(d, m, TABLE[t].cst, TABLE[t].mask, TABLE[t].zm, p);
            @(negedge clk); in_valid = 0;
            chk_vec($sformatf("table row %0d (R1..R8)", t), result, e);
            chk_bit("R9 out_valid one cycle later", out_valid, 1'b1);
        end
        // Direct expectations for R2 and R3 without the model
        drive(mk_data(8'h3C), {8{M_ID}}, 8'h00, '1, 1'b0, '0);
        @(negedge clk); in_valid = 0;
        chk_vec("R2 identity passes data", result, mk_data(8'h3C));
        drive({64{8'b1100_1010}}, {8{M_REV}}, 8'h00, '1, 1'b0, '0);
        @(negedge clk); in_valid = 0;
        chk_vec("R3 bit reverse", result, {64{8'b0101_0011}});

        // R4 per-group matrices: even groups identity, odd groups reverse
        mg = '0;
        for (int k = 0; k < 8; k++) mg[64*k +: 64] = (k % 2 == 0) ? M_ID : M_REV;
        e1 = model(mk_data(8'hE1), mg, 8'h00, '1, 1'b0, '0);
        drive(mk_data(8'hE1), mg, 8'h00, '1, 1'b0, '0);
        @(negedge clk); in_valid = 0;
        chk_vec("R4 group matrix selection", result, e1);

        // R10 back-to-back operations
        e1 = model(mk_data(8'h21), {8{M_ARB}}, 8'h0F, '1, 1'b0, '0);
        e2 = model(mk_data(8'h84), {8{M_REV}}, 8'hF0, 64'h00FF_00FF_00FF_00FF, 1'b1, '0);
        drive(mk_data(8'h21), {8{M_ARB}}, 8'h0F, '1, 1'b0, '0);
        @(negedge clk);
        chk_vec("R10 first of pair", result, e1);
        drive(mk_data(8'h84), {8{M_REV}}, 8'hF0, 64'h00FF_00FF_00FF_00FF, 1'b1, '0);
        @(negedge clk); in_valid = 0;
        chk_vec("R10 second of pair", result, e2);
        chk_bit("R10 out_valid stays high", out_valid, 1'b1);

        // R11 idle inputs do not disturb the result
        held = result;
        data_in = ~data_in; matrix_in = {8{M_ID}}; mask_in = '1;
        @(negedge clk);
        chk_bit("R11 out_valid drops", out_valid, 1'b0);
        @(negedge clk);
        chk_vec("R11 result held", result, held);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule